// File: doc/BRIEF.md
# Dual-Mode Control Word Latch

This block holds an eight-bit control word on its outputs: six data bits, a receive/transmit select bit and a PTL bit. Software-free hardware around it loads that word in one of two ways, chosen by the levels on the two upper data pins. In parallel mode the load pin works as a level-sensitive latch enable. The outputs follow the pins while it is high and freeze when it falls. In serial mode, two of the data pins turn into a data line and a clock line. Bits are shifted into a private register, and a low-high-low pulse on the load pin copies that register onto the outputs.

All pins are brought into the system clock domain through a two-stage synchroniser that comes out of reset at logic 1, so idle pins read high. Edges on the load pin and the serial clock are found from the synchronised levels. Each pin change reaches the outputs on the third system clock edge after it is sampled.

Top module: `ctl_word_latch`

## Requirements
- R1: While `rst_n` is low, `word_o` is all zeros.
- R2: In parallel mode with `ld_i` high, `word_o` follows the pins: `word_o[7:2]` = `dat_i[5:0]`, `word_o[1]` = `dir_i`, `word_o[0]` = `ptl_i`. It is updated within three clock cycles of a pin change.
- R3: In parallel mode, a falling `ld_i` freezes `word_o`. It stays frozen while `ld_i` is low, whatever the data pins do.
- R4: Serial mode is selected only when `dat_i[5]` = 1 and `dat_i[4]` = 0. Patterns 00, 01 and 11 on those two pins select parallel mode.
- R5: In serial mode, `dat_i[3]` is sampled on each rising edge of `dat_i[2]`. After eight edges, the first bit sampled sits in `word_o[7]` and the eighth in `word_o[0]` once transferred.
- R6: In serial mode, `word_o` does not change while bits are shifted in, nor while `ld_i` is high. It changes only when `ld_i` falls.
- R7: A strobe after fewer than eight serial clocks transfers the register as it stands, with the received bits in the low positions. After more than eight clocks, only the last eight bits are transferred.
- R8: Entering serial mode clears the shift register, so a strobe with no serial clocks transfers all zeros.
- R9: In serial mode, `dat_i[1:0]` have no effect on the shifted word or on `word_o`.
- R10: When the block leaves serial mode with `ld_i` low, `word_o` holds its value until `ld_i` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_i | input | 1 | Load pin: latch enable in parallel mode, transfer strobe in serial mode |
| dat_i | input | 6 | Data pins; bits 5/4 pick the mode, bits 3/2 are serial data/clock in serial mode |
| dir_i | input | 1 | Receive/transmit select bit (parallel mode) |
| ptl_i | input | 1 | PTL control bit (parallel mode) |
| word_o | output | 8 | Latched control word |

## Verification
A corrupted shift register cannot be seen while bits are being clocked in. It only shows on `word_o` three cycles after the next strobe falls, as bits displaced by position or left over from an earlier word. For that reason the bench ends every serial sequence with a strobe, covering short, full and over-long sequences as well as a re-entry with no clocks. A wrong mode or edge register shows up within three cycles of the pin change: the outputs either follow pins that should be ignored or stay put when a load was due. The bench therefore checks the outputs after every transition of `ld_i` and the mode pins.

// File: rtl/ctl_latch_pkg.sv
package ctl_latch_pkg;

  typedef enum logic {
    MODE_PAR = 1'b0,
    MODE_SER = 1'b1
  } mode_e;

  function automatic mode_e decode_mode(input logic hi, input logic lo);
    return (hi && !lo) ? MODE_SER : MODE_PAR;
  endfunction

endpackage

// File: rtl/ctl_in_sync.sv
module ctl_in_sync #(
  parameter int unsigned W      = 9,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '1;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/ctl_edge_mode.sv
module ctl_edge_mode
  import ctl_latch_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld_s,
  input  logic  sclk_s,
  input  logic  hi_s,
  input  logic  lo_s,
  output logic  ld_fall,
  output logic  sclk_rise,
  output logic  ser_enter,
  output mode_e mode_q
);

  logic  ld_prev_q, sclk_prev_q;
  mode_e mode_d;

  always_comb begin
    mode_d    = decode_mode(hi_s, lo_s);
    ld_fall   = ld_prev_q && !ld_s;
    sclk_rise = !sclk_prev_q && sclk_s;
    ser_enter = (mode_d == MODE_SER) && (mode_q == MODE_PAR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b1;
      mode_q      <= MODE_PAR;
    end else begin
      ld_prev_q   <= ld_s;
      sclk_prev_q <= sclk_s;
      mode_q      <= mode_d;
    end
  end

  // R4: once mode pins show the serial pattern for two cycles, mode is serial
  a_r4_mode_settles: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_s && !lo_s && $past(hi_s && !lo_s)) |-> (mode_q == MODE_SER));

endmodule

// File: rtl/ctl_ser_shift.sv
module ctl_ser_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         sdat,
  output logic [W-1:0] sh_q
);

  logic [W-1:0] sh_d;

  always_comb begin
    sh_d = sh_q;
    if (clr) begin
      sh_d = '0;
    end else if (shift_en) begin
      sh_d = {sh_q[W-2:0], sdat};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  a_r8_clear_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sh_q == '0));

  a_r5_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clr) |=> (sh_q[0] == $past(sdat)) &&
                           (sh_q[W-1:1] == $past(sh_q[W-2:0])));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !clr) |=> $stable(sh_q));

endmodule

// File: rtl/ctl_out_bank.sv
module ctl_out_bank
  import ctl_latch_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  mode_e        mode,
  input  logic         ld_lvl,
  input  logic         ld_fall,
  input  logic [W-1:0] par_word,
  input  logic [W-1:0] sh_word,
  output logic [W-1:0] word_q
);

  logic         load_en;
  logic [W-1:0] word_d;

  always_comb begin
    load_en = 1'b0;
    word_d  = word_q;
    if (mode == MODE_PAR && ld_lvl) begin
      load_en = 1'b1;
      word_d  = par_word;
    end else if (mode == MODE_SER && ld_fall) begin
      load_en = 1'b1;
      word_d  = sh_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (load_en) begin
      word_q <= word_d;
    end
  end

  a_r3_par_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PAR && !ld_lvl) |=> $stable(word_q));

  a_r6_ser_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SER && !ld_fall) |=> $stable(word_q));

  a_r5_ser_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SER && ld_fall) |=> (word_q == $past(sh_word)));

endmodule

// File: rtl/ctl_word_latch.sv
module ctl_word_latch
  import ctl_latch_pkg::*;
#(
  parameter int unsigned DATA_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] dat_i,
  input  logic              dir_i,
  input  logic              ptl_i,
  output logic [DATA_W+1:0] word_o
);

  localparam int unsigned WORD_W = DATA_W + 2;
  localparam int unsigned PIN_W  = WORD_W + 1;
  localparam int unsigned IX_LD  = WORD_W;
  localparam int unsigned IX_HI  = WORD_W - 1;
  localparam int unsigned IX_LO  = WORD_W - 2;
  localparam int unsigned IX_SD  = WORD_W - 3;
  localparam int unsigned IX_SC  = WORD_W - 4;

  logic             rst_meta_q, rst_sync_q;
  logic [PIN_W-1:0] pins_raw, pins_s;
  logic             ld_fall, sclk_rise, ser_enter;
  mode_e            mode_q;
  logic             shift_en;
  logic [WORD_W-1:0] sh_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign pins_raw = {ld_i, dat_i, dir_i, ptl_i};

  ctl_in_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .d     (pins_raw),
    .q     (pins_s)
  );

  ctl_edge_mode u_edge (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .ld_s      (pins_s[IX_LD]),
    .sclk_s    (pins_s[IX_SC]),
    .hi_s      (pins_s[IX_HI]),
    .lo_s      (pins_s[IX_LO]),
    .ld_fall   (ld_fall),
    .sclk_rise (sclk_rise),
    .ser_enter (ser_enter),
    .mode_q    (mode_q)
  );

  assign shift_en = (mode_q == MODE_SER) && sclk_rise;

  ctl_ser_shift #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .clr      (ser_enter),
    .shift_en (shift_en),
    .sdat     (pins_s[IX_SD]),
    .sh_q     (sh_word)
  );

  ctl_out_bank #(.W(WORD_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .mode     (mode_q),
    .ld_lvl   (pins_s[IX_LD]),
    .ld_fall  (ld_fall),
    .par_word (pins_s[WORD_W-1:0]),
    .sh_word  (sh_word),
    .word_q   (word_o)
  );

  // R1: outputs are zero whenever the external reset is asserted
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_zero: assert (word_o == '0);
    end
  end

endmodule

// File: tb/ctl_word_latch_tb.sv
module ctl_word_latch_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ld_i;
  logic [5:0] dat_i;
  logic       dir_i, ptl_i;
  logic [7:0] word_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0] exp_w;
  logic [7:0] exp_sh;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_word_latch u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_i   (ld_i),
    .dat_i  (dat_i),
    .dir_i  (dir_i),
    .ptl_i  (ptl_i),
    .word_o (word_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (word_o !== exp) begin
      n_fail++;
      $display("FAIL %s: word_o=%02h expected=%02h", req, word_o, exp);
    end
  endtask

  function automatic logic [7:0] no_ser(input logic [7:0] w);
    logic [7:0] r = w;
    if (r[7:6] == 2'b10) r[7] = 1'b0;
    return r;
  endfunction

  task automatic par_load(input logic [7:0] w, input string req);
    ld_i = 1'b0;
    {dat_i, dir_i, ptl_i} = w;
    step(SETTLE);
    ld_i = 1'b1;
    step(SETTLE);
    exp_w = w;
    check(req, exp_w);
    ld_i = 1'b0;
    step(SETTLE);
    {dat_i, dir_i, ptl_i} = no_ser(8'($urandom));
    step(SETTLE);
    check("R3", exp_w);
  endtask

  task automatic enter_ser();
    ld_i  = 1'b0;
    dat_i = 6'b10_0000;
    step(SETTLE);
    exp_sh = 8'h00;
  endtask

  task automatic ser_bit(input logic b);
    dat_i = {2'b10, b, 1'b0, 2'($urandom)};
    step(2);
    dat_i[2] = 1'b1;
    step(SETTLE);
    dat_i[2] = 1'b0;
    dat_i[1:0] = 2'($urandom);
    step(SETTLE);
    exp_sh = {exp_sh[6:0], b};
  endtask

  task automatic strobe(input string req);
    check("R6", exp_w);
    ld_i = 1'b1;
    step(SETTLE);
    check("R6", exp_w);
    ld_i = 1'b0;
    step(SETTLE);
    exp_w = exp_sh;
    check(req, exp_w);
  endtask

  task automatic ser_word(input logic [10:0] bits, input int nb, input string req);
    enter_ser();
    for (int i = nb - 1; i >= 0; i--) ser_bit(bits[i]);
    strobe(req);
  endtask

  task automatic leave_ser();
    ld_i = 1'b0;
    {dat_i, dir_i, ptl_i} = no_ser(8'($urandom));
    step(SETTLE);
    check("R10", exp_w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd4651);
    rst_n = 1'b0;
    ld_i  = 1'b1;
    dat_i = '1;
    dir_i = 1'b1;
    ptl_i = 1'b1;
    exp_w = 8'h00;
    exp_sh = 8'h00;
    step(3);
    check("R1", 8'h00);
    rst_n = 1'b1;
    step(SETTLE);
    exp_w = 8'hFF;
    check("R2", exp_w);

    // R2 / R4: directed patterns incl. 01 and 11 on the mode pins
    par_load(8'b0110_1001, "R4");
    par_load(8'b1101_0110, "R4");
    par_load(8'b0000_0000, "R2");
    par_load(8'b0011_1111, "R2");

    // R5: full eight-bit serial word, first bit lands in bit 7
    ser_word(11'b000_1011_0010, 8, "R5");
    leave_ser();
    // R8: re-entry with no clocks transfers zeros
    enter_ser();
    strobe("R8");
    leave_ser();
    // R7: short and long sequences
    ser_word(11'b000_0000_0101, 3, "R7");
    leave_ser();
    ser_word(11'b110_0111_0001, 11, "R7");
    // R9: another word while d1/d0 toggle randomly
    ser_word(11'b000_1111_0000, 8, "R9");
    leave_ser();

    for (int it = 0; it < 24; it++) begin
      if ($urandom % 2 == 0) begin
        par_load(no_ser(8'($urandom)), "R2");
      end else begin
        int nb;
        nb = 1 + int'($urandom % 11);
        ser_word(11'($urandom), nb, (nb == 8) ? "R5" : "R7");
        leave_ser();
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule